// File: doc/BRIEF.md
# Condition-Register Field Mask-Map Unit

This unit keeps a 32-bit condition register organised as eight 4-bit fields. It runs six operations that move data between a field and a 64-bit integer operand, or between two fields. Every operation shares one per-bit transform. The mask/map pair selects, inverts or forces the bits of a field. A flag then either reduces the transformed field to one bit or chooses how the destination's masked-out bits are treated: kept (read-modify-write) or cleared (plain overwrite).

An issuing stage presents one operation with `valid_i`. The register update and the integer result take effect on that clock edge, so the next operation can use the new register contents immediately. Integer-destination operations return their result with a one-cycle valid pulse. When asked, they also record a sign/zero summary of that result in field 0.

Top module: `crfm_unit`

## Requirements
- R1: While `rst_ni` is low, and until the first accepted operation after it, `cr_o` is all zeros and `res_valid_o` is 0.
- R2: Opcode 0 (reduce to integer): let creg be source field `bfa_i` and n = (~fmap XOR creg) AND fmsk. The result is 1 when n != 0 (flag `m_i`=1), or 1 when n == fmsk (flag 0). It is placed in bit 0 of `res_o`; all other bits are zero.
- R3: Opcode 1 (field to integer): `res_o` holds n from R2 in bits 3:0 and zeros elsewhere.
- R4: Opcode 2 (integer bit to field): bit 0 of the integer source is copied to all four positions to form creg. The integer source is 0 when `ra_zero_i`=1, otherwise `ra_i`. Field `bf_i` receives n OR (old field AND NOT fmsk) when `m_i`=1, and plain n when `m_i`=0. No other field changes.
- R5: Opcode 3 (integer nibble to field): as R4, with creg taken from bits 3:0 of the integer source.
- R6: Opcode 4 (masked field move): field `bf_i` receives ((fmsk AND field `bfa_i`) OR (`m_i` ? old field AND NOT fmsk : 0)) XOR fmap. Bits keep their position, and no other field changes.
- R7: Opcode 5 (reduce to register bit): the R2 result is written to register bit `bt_i` in MSB-first numbering, which is `cr_o[31-bt_i]`. The other 31 bits are unchanged.
- R8: For opcodes 0 and 1 with `rc_i`=1, field 0 becomes {res[63], res!=0 AND NOT res[63], res==0, `so_i`}, most significant bit first. With `rc_i`=0 the register is unchanged by these opcodes.
- R9: Field k occupies `cr_o[31-4k:28-4k]`. Bit 3 of fmsk/fmap applies to the most significant bit of a field.
- R10: `res_valid_o` is 1 for exactly the cycle after an accepted opcode 0 or 1, and 0 after any other opcode. Opcodes 6 and 7 change nothing.
- R11: When `valid_i` is 0, `cr_o` holds and `res_valid_o` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Operation present this cycle |
| op_i | input | 3 | Operation select (0..5) |
| m_i | input | 1 | Any/all reduce select, or keep-masked-bits select |
| fmsk_i | input | 4 | Per-bit field mask |
| fmap_i | input | 4 | Per-bit field map |
| bfa_i | input | 3 | Source field index |
| bf_i | input | 3 | Destination field index |
| bt_i | input | 5 | Destination register bit index (MSB-first) |
| ra_zero_i | input | 1 | Integer source forced to zero |
| ra_i | input | 64 | Integer source operand |
| rc_i | input | 1 | Record result summary in field 0 |
| so_i | input | 1 | Summary-overflow bit for field 0 |
| res_o | output | 64 | Integer result |
| res_valid_o | output | 1 | Integer result valid pulse |
| cr_o | output | 32 | Condition register |

## Verification
Every result is one register stage from its stimulus. Both `cr_o` and `res_o` with `res_valid_o` change on the first rising edge that samples `valid_i` high. `res_valid_o` falls again at the next edge. The bench drives each operation on a falling edge and drops `valid_i` on the next falling edge. It samples all outputs at that point, half a cycle after the capturing edge, and compares them with a register image it keeps itself. Initial field contents are loaded only through opcode 3 with a zero source, so every check runs through the normal ports.

// File: rtl/crfm_pkg.sv
package crfm_pkg;
  localparam int XLEN   = 64;
  localparam int NFLD   = 8;
  localparam int FW     = 4;
  localparam int OPW    = 3;

  typedef enum logic [OPW-1:0] {
    OP_RED_INT = 3'd0,
    OP_NIB_INT = 3'd1,
    OP_BIT_CR  = 3'd2,
    OP_NIB_CR  = 3'd3,
    OP_MOVE    = 3'd4,
    OP_RED_BIT = 3'd5
  } op_e;
endpackage

// File: rtl/crfm_field_rd.sv
module crfm_field_rd #(
  parameter int NFLD = 8,
  parameter int FW   = 4,
  localparam int CRW = NFLD * FW,
  localparam int FIW = $clog2(NFLD)
) (
  input  logic [CRW-1:0] cr_i,
  input  logic [FIW-1:0] idx_i,
  output logic [FW-1:0]  fld_o
);
  logic [FW-1:0] flds [NFLD];

  for (genvar k = 0; k < NFLD; k++) begin : g_fld
    // field 0 is the most significant slice
    assign flds[k] = cr_i[CRW-1-k*FW -: FW];
  end

  assign fld_o = flds[idx_i];
endmodule

// File: rtl/crfm_field_wr.sv
module crfm_field_wr #(
  parameter int NFLD = 8,
  parameter int FW   = 4,
  localparam int CRW = NFLD * FW,
  localparam int FIW = $clog2(NFLD)
) (
  input  logic [CRW-1:0] cr_i,
  input  logic           we_i,
  input  logic [FIW-1:0] idx_i,
  input  logic [FW-1:0]  fld_i,
  output logic [CRW-1:0] cr_o
);
  for (genvar k = 0; k < NFLD; k++) begin : g_fld
    assign cr_o[CRW-1-k*FW -: FW] = (we_i && idx_i == FIW'(k)) ? fld_i
                                                              : cr_i[CRW-1-k*FW -: FW];
  end
endmodule

// File: rtl/crfm_xform.sv
module crfm_xform #(
  parameter int FW = 4
) (
  input  logic [FW-1:0] creg_i,
  input  logic [FW-1:0] fmsk_i,
  input  logic [FW-1:0] fmap_i,
  input  logic          any_sel_i,
  output logic [FW-1:0] n_o,
  output logic          red_o
);
  logic any_hit, all_hit;

  assign n_o     = ~(fmap_i ^ creg_i) & fmsk_i;
  assign any_hit = |n_o;
  assign all_hit = (n_o == fmsk_i);
  assign red_o   = any_sel_i ? any_hit : all_hit;
endmodule

// File: rtl/crfm_cc_gen.sv
module crfm_cc_gen #(
  parameter int XLEN = 64,
  parameter int FW   = 4
) (
  input  logic [XLEN-1:0] res_i,
  input  logic            so_i,
  output logic [FW-1:0]   cc_o
);
  logic neg, zero;

  assign neg  = res_i[XLEN-1];
  assign zero = (res_i == '0);
  // lt, gt, eq, so from msb down; spare upper bits stay zero
  assign cc_o = FW'({neg, ~neg & ~zero, zero, so_i});
endmodule

// File: rtl/crfm_unit.sv
module crfm_unit
  import crfm_pkg::*;
#(
  parameter int XLEN_P = crfm_pkg::XLEN,
  parameter int NFLD_P = crfm_pkg::NFLD,
  parameter int FW_P   = crfm_pkg::FW,
  localparam int CRW   = NFLD_P * FW_P,
  localparam int FIW   = $clog2(NFLD_P),
  localparam int BTW   = $clog2(CRW)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [OPW-1:0]    op_i,
  input  logic              m_i,
  input  logic [FW_P-1:0]   fmsk_i,
  input  logic [FW_P-1:0]   fmap_i,
  input  logic [FIW-1:0]    bfa_i,
  input  logic [FIW-1:0]    bf_i,
  input  logic [BTW-1:0]    bt_i,
  input  logic              ra_zero_i,
  input  logic [XLEN_P-1:0] ra_i,
  input  logic              rc_i,
  input  logic              so_i,
  output logic [XLEN_P-1:0] res_o,
  output logic              res_valid_o,
  output logic [CRW-1:0]    cr_o
);
  logic [CRW-1:0]    cr_q;
  logic [XLEN_P-1:0] res_q;
  logic              res_valid_q;

  op_e               op;
  logic [FW_P-1:0]   src_fld, dst_fld, creg, n_val, keep, wr_fld, cc, fld_in;
  logic [XLEN_P-1:0] ra_val, res_nxt;
  logic              red, int_op, fld_we, bit_we;
  logic [FIW-1:0]    wr_idx;
  logic [CRW-1:0]    cr_fld, cr_nxt;

  assign op     = op_e'(op_i);
  assign ra_val = ra_zero_i ? '0 : ra_i;

  crfm_field_rd #(.NFLD(NFLD_P), .FW(FW_P)) u_rd_src (
    .cr_i(cr_q), .idx_i(bfa_i), .fld_o(src_fld)
  );

  crfm_field_rd #(.NFLD(NFLD_P), .FW(FW_P)) u_rd_dst (
    .cr_i(cr_q), .idx_i(bf_i), .fld_o(dst_fld)
  );

  always_comb begin
    unique case (op)
      OP_BIT_CR: creg = {FW_P{ra_val[0]}};
      OP_NIB_CR: creg = ra_val[FW_P-1:0];
      default:   creg = src_fld;
    endcase
  end

  crfm_xform #(.FW(FW_P)) u_xform (
    .creg_i(creg), .fmsk_i(fmsk_i), .fmap_i(fmap_i),
    .any_sel_i(m_i), .n_o(n_val), .red_o(red)
  );

  // read-modify-write keeps masked-out destination bits only when m_i
  assign keep = m_i ? (dst_fld & ~fmsk_i) : '0;

  always_comb begin
    int_op  = 1'b0;
    fld_we  = 1'b0;
    bit_we  = 1'b0;
    wr_fld  = '0;
    res_nxt = '0;
    unique case (op)
      OP_RED_INT: begin
        int_op  = 1'b1;
        res_nxt = XLEN_P'(red);
      end
      OP_NIB_INT: begin
        int_op  = 1'b1;
        res_nxt = XLEN_P'(n_val);
      end
      OP_BIT_CR, OP_NIB_CR: begin
        fld_we = 1'b1;
        wr_fld = n_val | keep;
      end
      OP_MOVE: begin
        fld_we = 1'b1;
        wr_fld = ((fmsk_i & src_fld) | keep) ^ fmap_i;
      end
      OP_RED_BIT: bit_we = 1'b1;
      default: ;
    endcase
  end

  crfm_cc_gen #(.XLEN(XLEN_P), .FW(FW_P)) u_cc (
    .res_i(res_nxt), .so_i(so_i), .cc_o(cc)
  );

  assign wr_idx = int_op ? '0 : bf_i;
  assign fld_in = int_op ? cc : wr_fld;

  crfm_field_wr #(.NFLD(NFLD_P), .FW(FW_P)) u_wr (
    .cr_i(cr_q), .we_i(fld_we | (int_op & rc_i)), .idx_i(wr_idx),
    .fld_i(fld_in), .cr_o(cr_fld)
  );

  always_comb begin
    cr_nxt = cr_fld;
    // bt_i counts from the most significant bit
    if (bit_we) cr_nxt[(CRW-1) - int'(bt_i)] = red;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cr_q        <= '0;
      res_q       <= '0;
      res_valid_q <= 1'b0;
    end else begin
      res_valid_q <= valid_i & int_op;
      if (valid_i) cr_q <= cr_nxt;
      if (valid_i && int_op) res_q <= res_nxt;
    end
  end

  assign cr_o        = cr_q;
  assign res_o       = res_q;
  assign res_valid_o = res_valid_q;
endmodule

// File: rtl/crfm_unit_chk.sv
module crfm_unit_chk #(
  parameter int XLEN_P = 64,
  parameter int NFLD_P = 8,
  parameter int FW_P   = 4,
  localparam int CRW   = NFLD_P * FW_P,
  localparam int FIW   = $clog2(NFLD_P),
  localparam int BTW   = $clog2(CRW)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [2:0]        op_i,
  input logic [FIW-1:0]    bf_i,
  input logic [BTW-1:0]    bt_i,
  input logic              rc_i,
  input logic              so_i,
  input logic [XLEN_P-1:0] res_o,
  input logic              res_valid_o,
  input logic [CRW-1:0]    cr_o
);
  logic [CRW-1:0] dst_mask;
  logic           fld_op, int_op;

  assign dst_mask = {{FW_P{1'b1}}, {(CRW-FW_P){1'b0}}} >> (int'(bf_i) * FW_P);
  assign fld_op   = valid_i && (op_i == 3'd2 || op_i == 3'd3 || op_i == 3'd4);
  assign int_op   = valid_i && (op_i == 3'd0 || op_i == 3'd1);

  // R2
  red_int_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd0) |=> (res_valid_o && res_o[XLEN_P-1:1] == '0));

  // R3
  nib_int_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd1) |=> (res_valid_o && res_o[XLEN_P-1:FW_P] == '0));

  // R6
  fld_only_dst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fld_op |=> (((cr_o ^ $past(cr_o)) & ~$past(dst_mask)) == '0));

  // R7
  one_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd5) |=> ($countones(cr_o ^ $past(cr_o)) <= 1));

  // R8
  rc_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_op && !rc_i) |=> $stable(cr_o));

  // R8
  rc_so_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_op && rc_i) |=> (cr_o[CRW-FW_P] == $past(so_i)));

  // R10
  valid_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> $past(int_op));

  // R11
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(cr_o) && !res_valid_o));
endmodule

bind crfm_unit crfm_unit_chk #(.XLEN_P(XLEN_P), .NFLD_P(NFLD_P), .FW_P(FW_P)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i), .bf_i(bf_i),
  .bt_i(bt_i), .rc_i(rc_i), .so_i(so_i), .res_o(res_o),
  .res_valid_o(res_valid_o), .cr_o(cr_o)
);

// File: tb/crfm_unit_test.sv
module crfm_unit_test;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        valid_i, m_i, ra_zero_i, rc_i, so_i;
  logic [2:0]  op_i, bfa_i, bf_i;
  logic [3:0]  fmsk_i, fmap_i;
  logic [4:0]  bt_i;
  logic [63:0] ra_i, res_o;
  logic        res_valid_o;
  logic [31:0] cr_o;

  logic [31:0] exp_cr;
  logic [63:0] exp_res;
  logic        exp_vld;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  crfm_unit uut (
    .clk_i, .rst_ni, .valid_i, .op_i, .m_i, .fmsk_i, .fmap_i, .bfa_i, .bf_i,
    .bt_i, .ra_zero_i, .ra_i, .rc_i, .so_i, .res_o, .res_valid_o, .cr_o
  );

  task automatic check(string req, logic [63:0] got, logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // one operation: drive on falling edge, sample half a cycle after capture
  task automatic run(string req, logic [2:0] op, logic m, logic [3:0] msk,
                     logic [3:0] map, logic [2:0] a, logic [2:0] d, logic [4:0] bt,
                     logic raz, logic [63:0] ra, logic rc, logic so);
    logic [3:0]  src, dst, creg, n, kp;
    logic [63:0] rav;
    logic        red;
    @(negedge clk_i);
    valid_i = 1; op_i = op; m_i = m; fmsk_i = msk; fmap_i = map; bfa_i = a;
    bf_i = d; bt_i = bt; ra_zero_i = raz; ra_i = ra; rc_i = rc; so_i = so;
    src  = exp_cr[31-4*a -: 4];
    dst  = exp_cr[31-4*d -: 4];
    rav  = raz ? 64'd0 : ra;
    creg = (op == 3'd2) ? {4{rav[0]}} : (op == 3'd3) ? rav[3:0] : src;
    n    = (~map ^ creg) & msk;
    red  = m ? (n != 4'd0) : (n == msk);
    kp   = m ? (dst & ~msk) : 4'd0;
    exp_vld = 0;
    case (op)
      3'd0: begin exp_res = {63'd0, red}; exp_vld = 1; end
      3'd1: begin exp_res = {60'd0, n};   exp_vld = 1; end
      3'd2, 3'd3: exp_cr[31-4*d -: 4] = n | kp;
      3'd4: exp_cr[31-4*d -: 4] = ((msk & src) | kp) ^ map;
      3'd5: exp_cr[31-bt] = red;
      default: ;
    endcase
    if (exp_vld && rc)
      exp_cr[31:28] = {exp_res[63], exp_res != 0 && !exp_res[63], exp_res == 0, so};
    @(negedge clk_i);
    valid_i = 0;
    check({req, " cr"}, 64'(cr_o), 64'(exp_cr));
    check({req, " valid"}, 64'(res_valid_o), 64'(exp_vld));
    if (exp_vld) check({req, " res"}, res_o, exp_res);
  endtask

  task automatic t_reset();
    check("R1 cr", 64'(cr_o), 64'd0);
    check("R1 valid", 64'(res_valid_o), 64'd0);
  endtask

  task automatic t_load();
    for (int k = 0; k < 8; k++)
      run("R5 load", 3'd3, 0, 4'hF, ~4'(k + 1), 0, 3'(k), 0, 1, 64'hFFFF, 0, 0);
    check("R9 layout", 64'(cr_o), 64'h1234_5678);
    check("R9 field0", 64'(cr_o[31:28]), 64'h1);
  endtask

  task automatic t_red_int();
    run("R2 all hit", 3'd0, 0, 4'b0011, 4'b0011, 3'd2, 0, 0, 0, 0, 0, 0);
    check("R2 all hit value", res_o, 64'd1);
    run("R2 all miss", 3'd0, 0, 4'b0011, 4'b0001, 3'd2, 0, 0, 0, 0, 0, 0);
    check("R2 all miss value", res_o, 64'd0);
    run("R2 any hit", 3'd0, 1, 4'b0011, 4'b0001, 3'd2, 0, 0, 0, 0, 0, 0);
    check("R2 any hit value", res_o, 64'd1);
    run("R2 any none", 3'd0, 1, 4'b1100, 4'b1111, 3'd2, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_nib_int();
    run("R3 nib", 3'd1, 0, 4'b1111, 4'b1010, 3'd6, 0, 0, 0, 0, 0, 0);
    run("R3 nib masked", 3'd1, 0, 4'b0110, 4'b0000, 3'd7, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_rc();
    run("R8 rc nonzero", 3'd1, 0, 4'b1111, 4'b1111, 3'd7, 0, 0, 0, 0, 1, 1);
    check("R8 field0 gt so", 64'(cr_o[31:28]), 64'b0101);
    run("R8 rc zero", 3'd0, 1, 4'b0000, 4'b0000, 3'd1, 0, 0, 0, 0, 1, 0);
    check("R8 field0 eq", 64'(cr_o[31:28]), 64'b0010);
  endtask

  task automatic t_bit_cr();
    run("R4 rmw", 3'd2, 1, 4'b0101, 4'b0000, 0, 3'd5, 0, 0, 64'h3, 0, 0);
    run("R4 overwrite", 3'd2, 0, 4'b0110, 4'b1111, 0, 3'd4, 0, 0, 64'h1, 0, 0);
    run("R4 ra zero", 3'd2, 0, 4'b1111, 4'b1111, 0, 3'd3, 0, 1, 64'hFF, 0, 0);
    check("R4 ra zero field", 64'(cr_o[19:16]), 64'b0000);
  endtask

  task automatic t_nib_cr();
    run("R5 nib rmw", 3'd3, 1, 4'b1100, 4'b1111, 0, 3'd6, 0, 0, 64'hF0A, 0, 0);
    run("R5 nib over", 3'd3, 0, 4'b1111, 4'b0000, 0, 3'd7, 0, 0, 64'h5, 0, 0);
    check("R5 nib over field", 64'(cr_o[3:0]), 64'b1010);
  endtask

  task automatic t_move();
    run("R6 move rmw", 3'd4, 1, 4'b0011, 4'b1001, 3'd7, 3'd1, 0, 0, 0, 0, 0);
    run("R6 move over", 3'd4, 0, 4'b1010, 4'b0001, 3'd5, 3'd2, 0, 0, 0, 0, 0);
    run("R6 move self", 3'd4, 1, 4'b1111, 4'b1111, 3'd6, 3'd6, 0, 0, 0, 0, 0);
  endtask

  task automatic t_red_bit();
    run("R7 bit msb", 3'd5, 1, 4'b1111, 4'b0000, 3'd0, 0, 5'd0, 0, 0, 0, 0);
    run("R7 bit lsb", 3'd5, 0, 4'b0011, 4'b0011, 3'd7, 0, 5'd31, 0, 0, 0, 0);
    run("R7 bit mid", 3'd5, 0, 4'b1000, 4'b1111, 3'd4, 0, 5'd13, 0, 0, 0, 0);
  endtask

  task automatic t_unused();
    run("R10 op6", 3'd6, 1, 4'hF, 4'hF, 3'd1, 3'd1, 5'd3, 0, 64'hF, 1, 1);
    run("R10 op7", 3'd7, 0, 4'hF, 4'h0, 3'd2, 3'd0, 5'd9, 0, 64'hF, 1, 1);
    run("R10 cr op no valid", 3'd3, 0, 4'hF, 4'h0, 0, 3'd3, 0, 0, 64'h9, 1, 0);
  endtask

  task automatic t_idle();
    logic [31:0] snap;
    run("R11 pre", 3'd1, 0, 4'hF, 4'h0, 3'd3, 0, 0, 0, 0, 0, 0);
    snap = cr_o;
    @(negedge clk_i);
    op_i = 3'd4; m_i = 0; fmsk_i = 4'hF; bf_i = 3'd0; rc_i = 1;
    repeat (3) @(negedge clk_i);
    check("R11 cr hold", 64'(cr_o), 64'(snap));
    check("R11 valid low", 64'(res_valid_o), 64'd0);
  endtask

  initial begin
    rst_ni = 0; valid_i = 0; op_i = 0; m_i = 0; fmsk_i = 0; fmap_i = 0;
    bfa_i = 0; bf_i = 0; bt_i = 0; ra_zero_i = 0; ra_i = 0; rc_i = 0; so_i = 0;
    exp_cr = '0; exp_res = '0; exp_vld = 0;
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1;
    @(negedge clk_i);
    t_reset();
    t_load();
    t_red_int();
    t_nib_int();
    t_rc();
    t_bit_cr();
    t_nib_cr();
    t_move();
    t_red_bit();
    t_unused();
    t_idle();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule